// File: doc/BRIEF.md
# Instruction Translation Cache with No-Execute and Reserved-Bit Screening

This block holds a small, fully associative set of instruction-side address translations. Each cycle it looks up the fetch address combinationally and returns either a hit with the physical address or a miss. When a fetch misses, an external page walker presents the four entries it read for a 64-bit, four-level walk. It also presents a flag for a 2 MiB leaf, the global no-execute enable and the implemented physical address width as an 8-bit value.

The block screens the page only at the moment it is filled. No screening happens on a hit. The screen looks for reserved bits in every entry that the walk used, and for a set no-execute flag when that feature is enabled. The enable also decides whether bit 63 is a flag or a reserved bit. A clean page is installed in the slot chosen by a round-robin pointer. A page that fails the screen is not installed, and the block reports a fault that says which kind of violation was found. A full flush empties the cache in one cycle.

Top module: `itlb_exec_guard`

## Requirements
- R1: A fetch lookup reports `fetch_hit` in the same cycle. For a 4 KiB entry, `fetch_pa` is the frame from leaf bits 51:12 joined with fetch address bits 11:0, and a matching entry is one whose stored bits 47:12 equal those of the fetch address.
- R2: A fill of a page that is not present gives its result on the clock edge after `fill_req`. The result is exactly one of three outputs: `fill_ok`, `flt_rsvd` or `flt_exec`. All three stay low in any cycle that does not follow an evaluated fill.
- R3: When `nx_on` is 1 and bit 63 is set in any entry the walk used, the fill reports `flt_exec` and installs nothing. Afterwards the page still misses.
- R4: When `nx_on` is 0, bit 63 of every entry the walk used is reserved. If it is set, the fill reports `flt_rsvd`.
- R5: In every entry the walk used, bits 51 down to `pa_bits` are reserved whatever `nx_on` is. When `pa_bits` is 52 or more, none of these bits is reserved.
- R6: For a 2 MiB leaf (`fill_big` = 1), bits 20:13 of the directory-level entry are reserved. For a 4 KiB leaf those bits are not reserved. With a 2 MiB leaf the lowest-level entry `walk_l1` is not examined.
- R7: A 2 MiB entry matches on fetch address bits 47:21. It returns the frame from directory bits 51:21 joined with fetch address bits 20:0.
- R8: When a reserved-bit violation and a no-execute violation occur together, only `flt_rsvd` is reported.
- R9: A fill whose address already hits is ignored. No result output is raised, the stored entry is left unchanged, and no new screening takes place.
- R10: There are 8 entries, and the victim is chosen round-robin. The pointer starts at slot 0 after reset or a flush and moves on by one for each installed page, so the ninth install replaces the first.
- R11: `flush` clears every entry in one cycle, and a fill presented in the same cycle is dropped with no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| fetch_va | input | 48 | Fetch virtual address |
| fetch_hit | output | 1 | Lookup hit (same cycle) |
| fetch_pa | output | 52 | Translated physical address, valid with hit |
| fill_req | input | 1 | Walk result presented for one cycle |
| fill_va | input | 48 | Virtual address of the walked page |
| walk_l4 | input | 64 | Top-level entry |
| walk_l3 | input | 64 | Second-level entry |
| walk_l2 | input | 64 | Directory-level entry (leaf when big) |
| walk_l1 | input | 64 | Lowest-level entry (leaf for 4 KiB) |
| fill_big | input | 1 | Walk ended in a 2 MiB leaf |
| nx_on | input | 1 | Global no-execute enable |
| pa_bits | input | 8 | Implemented physical address width |
| fill_ok | output | 1 | Page installed |
| flt_rsvd | output | 1 | Fault: reserved bit set |
| flt_exec | output | 1 | Fault: instruction fetch from a no-execute page |

## Verification
The assertions assume several things about the inputs. `fill_req` is only a one-cycle pulse. `nx_on` and `pa_bits` are taken to be constant only while a fill is being evaluated. Fills never build overlapping 4 KiB and 2 MiB entries, so at most one entry matches any fetch. The stimulus keeps to these assumptions: it presents each fill for one cycle and then leaves an idle cycle. It keeps the addresses of the 2 MiB pages apart from those of the 4 KiB pages. It changes `pa_bits` and `nx_on` only together with the fill they apply to.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

  localparam int ENT_W    = 64;
  localparam int WALK_LVL = 4;

  typedef enum logic [1:0] {
    LV_TOP   = 2'd0,
    LV_PTR   = 2'd1,
    LV_DIR   = 2'd2,
    LV_LEAF  = 2'd3
  } walk_lvl_e;

  typedef struct packed {
    logic rsvd;
    logic xd;
  } lvl_res_t;

  // Bits from top_bit down to the implemented width are unusable address bits.
  function automatic logic [ENT_W-1:0] addr_hole_mask(input logic [7:0] width,
                                                      input int top_bit);
    logic [ENT_W-1:0] m;
    m = '0;
    for (int i = 0; i < ENT_W; i++) begin
      if (i <= top_bit && i >= int'(width)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/itlb_lvl_chk.sv
module itlb_lvl_chk #(
  parameter int XD_BIT   = 63,
  parameter int ADDR_TOP = 51,
  parameter int BIG_LO   = 13,
  parameter int BIG_HI   = 20,
  parameter int HAS_BIG  = 0
) (
  input  logic [itlb_pkg::ENT_W-1:0] ent,
  input  logic                       nx_en,
  input  logic [7:0]                 pa_bits,
  input  logic                       big,
  input  logic                       used,
  output itlb_pkg::lvl_res_t         res
);
  logic [itlb_pkg::ENT_W-1:0] mask;

  always_comb begin
    mask = itlb_pkg::addr_hole_mask(pa_bits, ADDR_TOP);
    if (!nx_en) mask[XD_BIT] = 1'b1;
    if (HAS_BIG != 0 && big) mask[BIG_HI:BIG_LO] = '1;
  end

  assign res.rsvd = used & (|(ent & mask));
  assign res.xd   = used & nx_en & ent[XD_BIT];
endmodule

// File: rtl/itlb_rr.sv
module itlb_rr #(
  parameter int N = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          adv,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] ptr
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/itlb_cam.sv
module itlb_cam #(
  parameter int N      = 8,
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int PG_SH  = 12,
  parameter int LG_SH  = 21,
  parameter int NPROBE = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  flush,
  input  logic                                  wr_en,
  input  logic [((N > 1) ? $clog2(N) : 1)-1:0]  wr_idx,
  input  logic [VA_W-1:PG_SH]                   wr_vpn,
  input  logic                                  wr_big,
  input  logic [PA_W-1:PG_SH]                   wr_pfn,
  input  logic [VA_W-1:0]                       probe_va  [NPROBE],
  output logic                                  probe_hit [NPROBE],
  output logic [PA_W-1:0]                       probe_pa  [NPROBE]
);
  logic [N-1:0]        vld;
  logic [VA_W-1:PG_SH] tag_q [N];
  logic [PA_W-1:PG_SH] pfn_q [N];
  logic                big_q [N];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[wr_idx] <= 1'b1;
    end
  end

  // Payload arrays carry no reset so they can map onto plain storage.
  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx] <= wr_vpn;
      pfn_q[wr_idx] <= wr_pfn;
      big_q[wr_idx] <= wr_big;
    end
  end

  for (genvar p = 0; p < NPROBE; p++) begin : g_probe
    always_comb begin
      probe_hit[p] = 1'b0;
      probe_pa[p]  = '0;
      // Descending scan so the lowest matching slot wins.
      for (int e = N - 1; e >= 0; e--) begin
        if (vld[e]) begin
          if (big_q[e]) begin
            if (tag_q[e][VA_W-1:LG_SH] == probe_va[p][VA_W-1:LG_SH]) begin
              probe_hit[p] = 1'b1;
              probe_pa[p]  = {pfn_q[e][PA_W-1:LG_SH], probe_va[p][LG_SH-1:0]};
            end
          end else begin
            if (tag_q[e] == probe_va[p][VA_W-1:PG_SH]) begin
              probe_hit[p] = 1'b1;
              probe_pa[p]  = {pfn_q[e], probe_va[p][PG_SH-1:0]};
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/itlb_exec_guard.sv
module itlb_exec_guard #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int PG_SH   = 12,
  parameter int LG_SH   = 21
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic [VA_W-1:0] fetch_va,
  output logic            fetch_hit,
  output logic [PA_W-1:0] fetch_pa,
  input  logic            fill_req,
  input  logic [VA_W-1:0] fill_va,
  input  logic [63:0]     walk_l4,
  input  logic [63:0]     walk_l3,
  input  logic [63:0]     walk_l2,
  input  logic [63:0]     walk_l1,
  input  logic            fill_big,
  input  logic            nx_on,
  input  logic [7:0]      pa_bits,
  output logic            fill_ok,
  output logic            flt_rsvd,
  output logic            flt_exec
);
  import itlb_pkg::*;

  localparam int IW       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int ADDR_TOP = PA_W - 1;
  localparam int BIG_LO   = PG_SH + 1;
  localparam int BIG_HI   = LG_SH - 1;

  logic [ENT_W-1:0] lvl_ent [WALK_LVL];
  lvl_res_t         lvl_res [WALK_LVL];
  logic [WALK_LVL-1:0] lvl_rsvd, lvl_xd;

  assign lvl_ent[LV_TOP]  = walk_l4;
  assign lvl_ent[LV_PTR]  = walk_l3;
  assign lvl_ent[LV_DIR]  = walk_l2;
  assign lvl_ent[LV_LEAF] = walk_l1;

  for (genvar g = 0; g < WALK_LVL; g++) begin : g_lvl
    itlb_lvl_chk #(
      .XD_BIT  (ENT_W - 1),
      .ADDR_TOP(ADDR_TOP),
      .BIG_LO  (BIG_LO),
      .BIG_HI  (BIG_HI),
      .HAS_BIG ((g == int'(LV_DIR)) ? 1 : 0)
    ) u_lvl (
      .ent    (lvl_ent[g]),
      .nx_en  (nx_on),
      .pa_bits(pa_bits),
      .big    (fill_big),
      .used   ((g == int'(LV_LEAF)) ? ~fill_big : 1'b1),
      .res    (lvl_res[g])
    );
    assign lvl_rsvd[g] = lvl_res[g].rsvd;
    assign lvl_xd[g]   = lvl_res[g].xd;
  end

  logic            any_rsvd, any_xd;
  logic            present, take, install;
  logic [IW-1:0]   victim;
  logic [PA_W-1:PG_SH] new_pfn;
  logic [VA_W-1:0] probe_va  [2];
  logic            probe_hit [2];
  logic [PA_W-1:0] probe_pa  [2];
  logic [PA_W-1:0] unused_pa;

  assign any_rsvd = |lvl_rsvd;
  assign any_xd   = |lvl_xd;

  assign probe_va[0] = fetch_va;
  assign probe_va[1] = fill_va;
  assign fetch_hit   = probe_hit[0];
  assign fetch_pa    = probe_pa[0];
  assign present     = probe_hit[1];
  assign unused_pa   = probe_pa[1];

  assign take    = fill_req && !flush && !present;
  assign install = take && !any_rsvd && !any_xd;
  assign new_pfn = fill_big ? {walk_l2[PA_W-1:LG_SH], {(LG_SH-PG_SH){1'b0}}}
                            : walk_l1[PA_W-1:PG_SH];

  itlb_rr #(.N(ENTRIES)) u_rr (
    .clk(clk), .rst(rst), .clr(flush), .adv(install), .ptr(victim)
  );

  itlb_cam #(
    .N(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .PG_SH(PG_SH), .LG_SH(LG_SH), .NPROBE(2)
  ) u_cam (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .wr_en    (install),
    .wr_idx   (victim),
    .wr_vpn   (fill_va[VA_W-1:PG_SH]),
    .wr_big   (fill_big),
    .wr_pfn   (new_pfn),
    .probe_va (probe_va),
    .probe_hit(probe_hit),
    .probe_pa (probe_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_ok  <= 1'b0;
      flt_rsvd <= 1'b0;
      flt_exec <= 1'b0;
    end else begin
      fill_ok  <= install;
      flt_rsvd <= take && any_rsvd;
      flt_exec <= take && !any_rsvd && any_xd;
    end
  end
endmodule

// File: rtl/itlb_exec_guard_chk.sv
module itlb_exec_guard_chk (
  input logic clk,
  input logic rst,
  input logic flush,
  input logic fill_req,
  input logic nx_on,
  input logic fetch_hit,
  input logic fill_ok,
  input logic flt_rsvd,
  input logic flt_exec
);
  // R8: at most one result flag per cycle
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fill_ok, flt_rsvd, flt_exec}));

  // R2: any result follows a fill that was not cancelled by a flush
  a_r2_result_follows_fill: assert property (@(posedge clk) disable iff (rst)
    (fill_ok || flt_rsvd || flt_exec) |-> ($past(fill_req) && !$past(flush)));

  // R3: a no-execute fault needs the enable in the evaluated cycle
  a_r3_exec_needs_enable: assert property (@(posedge clk) disable iff (rst)
    flt_exec |-> $past(nx_on));

  // R11: the cycle after a flush sees an empty cache
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> !fetch_hit);
endmodule

bind itlb_exec_guard itlb_exec_guard_chk u_chk (
  .clk(clk), .rst(rst), .flush(flush), .fill_req(fill_req), .nx_on(nx_on),
  .fetch_hit(fetch_hit), .fill_ok(fill_ok), .flt_rsvd(flt_rsvd), .flt_exec(flt_exec)
);

// File: tb/itlb_exec_guard_tb.sv
module itlb_exec_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic [47:0] fetch_va = '0;
  logic        fetch_hit;
  logic [51:0] fetch_pa;
  logic        fill_req = 1'b0;
  logic [47:0] fill_va = '0;
  logic [63:0] walk_l4 = '0, walk_l3 = '0, walk_l2 = '0, walk_l1 = '0;
  logic        fill_big = 1'b0;
  logic        nx_on = 1'b0;
  logic [7:0]  pa_bits = 8'd46;
  logic        fill_ok, flt_rsvd, flt_exec;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    bit    ok;
    bit    rs;
    bit    ex;
    string req;
  } exp_t;
  exp_t sbq[$];

  localparam logic [63:0] CL4 = 64'h0000_0000_0001_1007;
  localparam logic [63:0] CL3 = 64'h0000_0000_0002_2007;
  localparam logic [63:0] CL2 = 64'h0000_0000_0003_3007;
  localparam logic [63:0] XDB = 64'h8000_0000_0000_0000;

  always #10 clk = ~clk;

  itlb_exec_guard u_dut (
    .clk(clk), .rst(rst), .flush(flush), .fetch_va(fetch_va), .fetch_hit(fetch_hit),
    .fetch_pa(fetch_pa), .fill_req(fill_req), .fill_va(fill_va), .walk_l4(walk_l4),
    .walk_l3(walk_l3), .walk_l2(walk_l2), .walk_l1(walk_l1), .fill_big(fill_big),
    .nx_on(nx_on), .pa_bits(pa_bits), .fill_ok(fill_ok), .flt_rsvd(flt_rsvd),
    .flt_exec(flt_exec)
  );

  task automatic do_fill(input logic [47:0] va, input logic [63:0] a, b, c, d,
                         input bit big, nx, input logic [7:0] pb, input bit fl,
                         input bit eo, er, ee, input string req);
    exp_t e;
    @(negedge clk);
    fill_req = 1'b1; fill_va = va; walk_l4 = a; walk_l3 = b; walk_l2 = c; walk_l1 = d;
    fill_big = big; nx_on = nx; pa_bits = pb; flush = fl;
    e.ok = eo; e.rs = er; e.ex = ee; e.req = req;
    sbq.push_back(e);
    @(negedge clk);
    fill_req = 1'b0; flush = 1'b0;
  endtask

  task automatic look(input logic [47:0] va, input bit eh, input logic [51:0] epa,
                      input string req);
    @(negedge clk);
    fetch_va = va;
    #2;
    checks++;
    if (fetch_hit !== eh || (eh && fetch_pa !== epa)) begin
      fails++;
      $display("FAIL %s: va=%h hit=%b pa=%h expected hit=%b pa=%h",
               req, va, fetch_hit, fetch_pa, eh, epa);
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // Monitor: pops one expectation per evaluated fill, otherwise demands silence.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst) begin
        if (sbq.size() > 0) begin
          exp_t e;
          e = sbq.pop_front();
          checks++;
          if ({fill_ok, flt_rsvd, flt_exec} !== {e.ok, e.rs, e.ex}) begin
            fails++;
            $display("FAIL %s: ok/rsvd/exec=%b%b%b expected %b%b%b",
                     e.req, fill_ok, flt_rsvd, flt_exec, e.ok, e.rs, e.ex);
          end
        end else if (fill_ok || flt_rsvd || flt_exec) begin
          checks++;
          fails++;
          $display("FAIL R2: idle result ok/rsvd/exec=%b%b%b expected 000",
                   fill_ok, flt_rsvd, flt_exec);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset state
    look(48'h0000_1234_5abc, 1'b0, '0, "R11 reset empty");
    checks++;
    if (fill_ok || flt_rsvd || flt_exec) begin
      fails++;
      $display("FAIL R2: reset flags=%b%b%b expected 000", fill_ok, flt_rsvd, flt_exec);
    end

    // R1 clean 4 KiB install and lookup
    do_fill(48'h0000_1234_5000, CL4, CL3, CL2, 64'h0000_0012_3456_7007,
            0, 1, 8'd46, 0, 1, 0, 0, "R1 clean fill");
    look(48'h0000_1234_5abc, 1'b1, 52'h0_0012_3456_7abc, "R1 hit frame+offset");
    look(48'h0000_1234_6abc, 1'b0, '0, "R1 neighbour miss");

    // R3 no-execute flag in second level, enabled
    do_fill(48'h0000_2000_0000, CL4, CL3 | XDB, CL2, 64'h0000_0000_0050_0007,
            0, 1, 8'd46, 0, 0, 0, 1, "R3 exec fault");
    look(48'h0000_2000_0010, 1'b0, '0, "R3 not installed");
    // R4 same walk with enable off
    do_fill(48'h0000_2000_0000, CL4, CL3 | XDB, CL2, 64'h0000_0000_0050_0007,
            0, 0, 8'd46, 0, 0, 1, 0, "R4 bit63 reserved");
    // R4 bit 63 in leaf with enable off
    do_fill(48'h0000_2000_0000, CL4, CL3, CL2, 64'h8000_0000_0050_0007,
            0, 0, 8'd46, 0, 0, 1, 0, "R4 leaf bit63 reserved");

    // R5 address width boundary
    do_fill(48'h0000_2000_0000, 64'h0000_2000_0000_0007, CL3, CL2, 64'h0000_0000_0050_0007,
            0, 1, 8'd40, 0, 0, 1, 0, "R5 bit45 over width 40");
    do_fill(48'h0000_2000_0000, CL4, CL3, 64'h0008_0000_0000_0007, 64'h0000_0000_0050_0007,
            0, 1, 8'd51, 0, 0, 1, 0, "R5 bit51 over width 51");
    do_fill(48'h0000_2000_0000, CL4, CL3, 64'h0008_0000_0000_0007, 64'h0000_0000_0050_0007,
            0, 1, 8'd52, 0, 1, 0, 0, "R5 width 52 no holes");
    look(48'h0000_2000_0123, 1'b1, 52'h0_0000_0050_0123, "R5 installed");

    // R6 big leaf reserved 20:13, not reserved for small leaf
    do_fill(48'h0000_4060_0000, CL4, CL3, 64'h0000_0000_8040_8087, '0,
            1, 1, 8'd46, 0, 0, 1, 0, "R6 big bit15 reserved");
    do_fill(48'h0000_6000_0000, CL4, CL3, 64'h0000_0000_0000_8007, 64'h0000_0000_0060_0007,
            0, 1, 8'd46, 0, 1, 0, 0, "R6 small bit15 allowed");
    // R6/R7 big leaf ignores lowest level even with its bit63 set
    do_fill(48'h0000_4060_0000, CL4, CL3, 64'h0000_0000_8040_0087, XDB,
            1, 1, 8'd46, 0, 1, 0, 0, "R6 big leaf skips l1");
    look(48'h0000_405f_f123, 1'b0, '0, "R7 below big page");
    look(48'h0000_407f_f123, 1'b1, 52'h0_0000_805f_f123, "R7 big offset 20:0");
    look(48'h0000_4080_0000, 1'b0, '0, "R7 next big page miss");

    // R8 both violations: reserved wins
    do_fill(48'h0000_7000_0000, 64'h0000_8000_0000_0007, CL3 | XDB, CL2, 64'h0000_0000_0070_0007,
            0, 1, 8'd46, 0, 0, 1, 0, "R8 reserved over exec");

    // R9 fill of present page ignored
    do_fill(48'h0000_1234_5000, CL4, CL3, CL2 | XDB, 64'h0000_0000_0099_9007,
            0, 1, 8'd46, 0, 0, 0, 0, "R9 present fill ignored");
    look(48'h0000_1234_5001, 1'b1, 52'h0_0012_3456_7001, "R9 entry unchanged");

    // R11 flush and same-cycle fill dropped
    do_flush();
    look(48'h0000_1234_5001, 1'b0, '0, "R11 flushed");
    do_fill(48'h0000_3000_0000, CL4, CL3, CL2, 64'h0000_0000_0030_0007,
            0, 1, 8'd46, 1, 0, 0, 0, "R11 fill with flush dropped");
    look(48'h0000_3000_0000, 1'b0, '0, "R11 dropped fill absent");

    // R10 round robin over 8 slots
    do_flush();
    for (int i = 0; i < 9; i++) begin
      do_fill(48'h0001_0000_0000 + (48'(i) << 12), CL4, CL3, CL2,
              64'h0000_0000_0100_0007 + (64'(i) << 12),
              0, 1, 8'd46, 0, 1, 0, 0, "R10 fill");
    end
    look(48'h0001_0000_0000, 1'b0, '0, "R10 first evicted");
    look(48'h0001_0000_1004, 1'b1, 52'h0_0000_0100_1004, "R10 second kept");
    look(48'h0001_0000_8008, 1'b1, 52'h0_0000_0100_8008, "R10 ninth present");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule